// File: doc/BRIEF.md
# Glitch-Hardened 2-of-7 Link Receiver

This block terminates the receive side of a serial inter-chip link. It carries one symbol at a time on seven wires using transition signalling: a symbol is sent by flipping the level of exactly two wires. The receiver is modelled on a single clock. It compares each wire against the level it last captured for that wire, so it does not care about the absolute polarity on the line. When two wires have flipped, it decodes the pair into a 4-bit flit or an end-of-packet marker. The result is presented on a valid/ready port, and the receiver flips its acknowledge wire so the transmitter can send the next symbol.

Noise on the wires is absorbed rather than allowed to lock up the link. When more than two flips are seen, a fixed-priority arbiter keeps the two lowest-numbered wires and takes the others into the reference levels. A lone flip with no partner inside a programmable window is treated as noise and dropped. When the receiver leaves reset on its own, it sends one spare acknowledge, because the far side may be waiting for one. The transmitter is built to absorb this token if it does not need it.

Top module: `rx_link_receiver`

## Requirements
- R1: While rst_ni is low, flit_valid_o and ack_o are 0.
- R2: On the first rising clock edge after reset is released, the current level of every link wire is taken as its reference, no flit is produced, and ack_o flips once.
- R3: Code mapping. For a symbol on wires a<b, the index is the position of (a,b) when all pairs are listed with a ascending, then b ascending: (0,1)=0, (0,2)=1, …, (5,6)=20. An index below 16 yields a data flit with flit_data_o equal to the index and flit_eop_o=0. Index 20 (wires 5 and 6) yields flit_eop_o=1 with flit_data_o=0. Indices 16 to 19 are acknowledged but produce no flit.
- R4: A symbol completes on the clock edge at which the second wire flip is seen, whether the two flips arrive in the same cycle or in different cycles. After that edge, flit_valid_o (for flit-producing codes) and the flipped ack_o are both visible.
- R5: When three or more wires have flipped, counting a flip already pending, the two lowest-numbered wires form the symbol. The other flips are absorbed into the reference levels and have no effect on later symbols.
- R6: A single pending flip is discarded, with no flit and no ack, if no second flip arrives within GLITCH_TIMEOUT clock edges. A second flip that arrives exactly GLITCH_TIMEOUT edges after the first still completes the symbol.
- R7: While flit_valid_o=1 and flit_ready_i=0, the flit outputs hold, the link is not sampled, and ack_o does not change.
- R8: After a flit is taken (valid and ready both high at an edge), flit_valid_o falls unless a new symbol completes on that same edge.
- R9: A flip is detected in either direction, relative to the last captured level of each wire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| link_i | input | NUM_WIRES | Transition-signalled link wires |
| flit_ready_i | input | 1 | Downstream ready |
| flit_valid_o | output | 1 | Flit present |
| flit_data_o | output | 4 | Decoded data nibble |
| flit_eop_o | output | 1 | End-of-packet marker |
| ack_o | output | 1 | Transition acknowledge to transmitter |

## Verification
The assertions assume that link_i is already synchronous to clk_i. They also assume the transmitter starts a new symbol only after it has seen the acknowledge for the previous one, so the link is quiet while a completed flit waits on a low ready. The bench changes link_i and flit_ready_i only on falling edges. It sends each symbol only after the previous symbol's acknowledge has been observed. The only exceptions are the deliberate noise cases, where it injects extra or lone flips to exercise arbitration and timeout discard.

// File: rtl/rx_link_pkg.sv
package rx_link_pkg;
  localparam int unsigned FLIT_W = 4;

  typedef struct packed {
    logic              eop;
    logic [FLIT_W-1:0] data;
  } flit_t;
endpackage

// File: rtl/rx_edge_track.sv
module rx_edge_track #(
  parameter int unsigned NUM_WIRES = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WIRES-1:0] link_i,
  input  logic                 capture_i,
  output logic [NUM_WIRES-1:0] toggle_o
);
  logic [NUM_WIRES-1:0] ref_q;

  for (genvar g = 0; g < NUM_WIRES; g++) begin : g_wire
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        ref_q[g] <= 1'b0;
      else if (capture_i) ref_q[g] <= link_i[g];
    end
    // phase-insensitive: any difference from last captured level is a flip
    assign toggle_o[g] = link_i[g] ^ ref_q[g];
  end
endmodule

// File: rtl/rx_pair_arbiter.sv
module rx_pair_arbiter #(
  parameter int unsigned NUM_WIRES = 7,
  localparam int unsigned IDX_W = $clog2(NUM_WIRES)
) (
  input  logic [NUM_WIRES-1:0] cand_i,
  output logic [IDX_W-1:0]     lo_o,
  output logic [IDX_W-1:0]     hi_o,
  output logic                 any_o,
  output logic                 pair_o
);
  // fixed priority: lowest index wins, extras are dropped
  always_comb begin
    lo_o   = '0;
    hi_o   = '0;
    any_o  = 1'b0;
    pair_o = 1'b0;
    for (int i = 0; i < NUM_WIRES; i++) begin
      if (cand_i[i]) begin
        if (!any_o) begin
          lo_o  = IDX_W'(i);
          any_o = 1'b1;
        end else if (!pair_o) begin
          hi_o   = IDX_W'(i);
          pair_o = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rx_pair_decode.sv
module rx_pair_decode
  import rx_link_pkg::*;
#(
  parameter int unsigned NUM_WIRES = 7,
  localparam int unsigned IDX_W     = $clog2(NUM_WIRES),
  localparam int          NUM_CODES = NUM_WIRES * (NUM_WIRES - 1) / 2,
  localparam int          DATA_CODES = 2 ** FLIT_W
) (
  input  logic [IDX_W-1:0] lo_i,
  input  logic [IDX_W-1:0] hi_i,
  output logic             emit_o,
  output flit_t            flit_o
);
  int lo, hi, idx;

  always_comb begin
    lo  = int'(lo_i);
    hi  = int'(hi_i);
    idx = lo * (2 * NUM_WIRES - 1 - lo) / 2 + hi - lo - 1;
    flit_o = '0;
    emit_o = 1'b0;
    if (idx == NUM_CODES - 1) begin
      emit_o     = 1'b1;
      flit_o.eop = 1'b1;
    end else if (idx < DATA_CODES) begin
      emit_o      = 1'b1;
      flit_o.data = FLIT_W'(idx);
    end
  end
endmodule

// File: rtl/rx_link_receiver.sv
module rx_link_receiver
  import rx_link_pkg::*;
#(
  parameter int unsigned NUM_WIRES      = 7,
  parameter int unsigned GLITCH_TIMEOUT = 8,
  localparam int unsigned IDX_W = $clog2(NUM_WIRES),
  localparam int unsigned TMR_W = $clog2(GLITCH_TIMEOUT + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_WIRES-1:0] link_i,
  input  logic                 flit_ready_i,
  output logic                 flit_valid_o,
  output logic [FLIT_W-1:0]    flit_data_o,
  output logic                 flit_eop_o,
  output logic                 ack_o
);
  localparam logic [TMR_W-1:0] TMR_LIM = TMR_W'(GLITCH_TIMEOUT - 1);

  logic                 boot_q, ack_q, ack_d;
  logic [NUM_WIRES-1:0] pend_q, pend_d, tog, cand;
  logic [TMR_W-1:0]     tmr_q, tmr_d;
  logic                 stall, run, complete;
  logic [IDX_W-1:0]     lo, hi;
  logic                 any, pair, emit;
  flit_t                dec, out_q;
  logic                 valid_q;

  assign stall = valid_q & ~flit_ready_i;
  assign run   = ~boot_q & ~stall;

  rx_edge_track #(.NUM_WIRES(NUM_WIRES)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .link_i   (link_i),
    .capture_i(boot_q | run),
    .toggle_o (tog)
  );

  assign cand = pend_q | (run ? tog : '0);

  rx_pair_arbiter #(.NUM_WIRES(NUM_WIRES)) u_arb (
    .cand_i(cand),
    .lo_o  (lo),
    .hi_o  (hi),
    .any_o (any),
    .pair_o(pair)
  );

  rx_pair_decode #(.NUM_WIRES(NUM_WIRES)) u_dec (
    .lo_i  (lo),
    .hi_i  (hi),
    .emit_o(emit),
    .flit_o(dec)
  );

  always_comb begin
    pend_d   = pend_q;
    tmr_d    = tmr_q;
    ack_d    = ack_q;
    complete = 1'b0;
    if (boot_q) begin
      ack_d = ~ack_q;  // spare token after independent reset
    end else if (run) begin
      if (pair) begin
        complete = 1'b1;
        pend_d   = '0;
        tmr_d    = '0;
        ack_d    = ~ack_q;
      end else if (any) begin
        pend_d = cand;
        if (tog == '0) begin
          if (tmr_q == TMR_LIM) begin
            pend_d = '0;
            tmr_d  = '0;
          end else begin
            tmr_d = tmr_q + 1'b1;
          end
        end else begin
          tmr_d = '0;
        end
      end else begin
        tmr_d = '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      boot_q  <= 1'b1;
      ack_q   <= 1'b0;
      pend_q  <= '0;
      tmr_q   <= '0;
      valid_q <= 1'b0;
      out_q   <= '0;
    end else begin
      boot_q <= 1'b0;
      ack_q  <= ack_d;
      pend_q <= pend_d;
      tmr_q  <= tmr_d;
      if (complete && emit) begin
        valid_q <= 1'b1;
        out_q   <= dec;
      end else if (flit_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign flit_valid_o = valid_q;
  assign flit_data_o  = out_q.data;
  assign flit_eop_o   = out_q.eop;
  assign ack_o        = ack_q;
endmodule

// File: rtl/rx_link_receiver_chk.sv
module rx_link_receiver_chk #(
  parameter int unsigned NUM_WIRES = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ready_i,
  input logic                 valid_i,
  input logic [3:0]           data_i,
  input logic                 eop_i,
  input logic                 ack_i,
  input logic                 boot_i,
  input logic [NUM_WIRES-1:0] pend_i
);
  a_r7_hold_flit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> valid_i && $stable(data_i) && $stable(eop_i));

  a_r7_hold_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !ready_i |=> $stable(ack_i));

  a_r3_eop_zero_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && eop_i |-> data_i == 4'd0);

  a_r5_single_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pend_i));

  a_r2_boot_token: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_i |=> ack_i != $past(ack_i) && !valid_i);

  a_r4_flit_with_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_i) |-> ack_i != $past(ack_i));
endmodule

bind rx_link_receiver rx_link_receiver_chk #(.NUM_WIRES(NUM_WIRES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ready_i(flit_ready_i),
  .valid_i(flit_valid_o),
  .data_i (flit_data_o),
  .eop_i  (flit_eop_o),
  .ack_i  (ack_o),
  .boot_i (boot_q),
  .pend_i (pend_q)
);

// File: tb/sim_rx_link_receiver.sv
module sim_rx_link_receiver;
  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] link = 7'b1011001;
  logic       ready = 1'b1;
  logic       valid, eop, ack;
  logic [3:0] data;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [6:0] lnk = 7'b1011001;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rx_link_receiver #(.NUM_WIRES(7), .GLITCH_TIMEOUT(TIMEOUT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .link_i(link), .flit_ready_i(ready),
    .flit_valid_o(valid), .flit_data_o(data), .flit_eop_o(eop), .ack_o(ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pair_idx(input int a, input int b);
    int n = 0;
    for (int x = 0; x < 7; x++)
      for (int y = x + 1; y < 7; y++) begin
        if (x == a && y == b) return n;
        n++;
      end
    return -1;
  endfunction

  // flips wires in m, passes one rising edge, returns at falling edge
  task automatic send(input logic [6:0] m);
    lnk  = lnk ^ m;
    link = lnk;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_sym(input int idx, input logic ack_before, input string req);
    chk(ack != ack_before, req, ack, !ack_before);
    if (idx < 16) begin
      chk(valid && !eop && data == idx[3:0], req, {valid, eop, data}, {2'b10, idx[3:0]});
    end else if (idx == 20) begin
      chk(valid && eop && data == 0, req, {valid, eop, data}, 6'b110000);
    end else begin
      chk(!valid, req, valid, 0);
    end
  endtask

  task automatic t_reset;
    #(CLK_PERIOD * 2);
    chk(!valid && !ack, "R1", {valid, ack}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack == 1'b1, "R2 boot ack", ack, 1);
    chk(!valid, "R2 boot no flit", valid, 0);
    idle(2);
    chk(!valid && ack == 1'b1, "R9 start levels absorbed", {valid, ack}, 2'b01);
  endtask

  task automatic t_all_codes;
    for (int a = 0; a < 7; a++)
      for (int b = a + 1; b < 7; b++) begin
        logic ab = ack;
        send(7'(1 << a) | 7'(1 << b));
        expect_sym(pair_idx(a, b), ab, "R3 code");
        idle(1);
      end
  endtask

  task automatic t_split;
    logic ab = ack;
    send(7'b0001000);
    chk(!valid && ack == ab, "R4 half symbol", {valid, ack}, {1'b0, ab});
    send(7'b0100000);
    expect_sym(pair_idx(3, 5), ab, "R4 split");
    idle(1);
    chk(!valid, "R8 valid falls", valid, 0);
  endtask

  task automatic t_arbitrate;
    logic ab = ack;
    send(7'b0000111);
    expect_sym(0, ab, "R5 three flips");
    idle(1);
    ab = ack;
    send(7'b0011000);
    expect_sym(pair_idx(3, 4), ab, "R5 extra absorbed");
    idle(1);
    ab = ack;
    send(7'b1000000);
    send(7'b0000110);
    expect_sym(pair_idx(1, 2), ab, "R5 pending loses");
    idle(1);
    ab = ack;
    send(7'b1100000);
    expect_sym(20, ab, "R5 pending cleared");
    idle(1);
  endtask

  task automatic t_timeout;
    logic ab = ack;
    send(7'b0000001);
    idle(TIMEOUT - 1);
    send(7'b0000100);
    expect_sym(pair_idx(0, 2), ab, "R6 boundary");
    idle(1);
    ab = ack;
    send(7'b0000001);
    idle(TIMEOUT);
    send(7'b0000100);
    chk(!valid && ack == ab, "R6 glitch dropped", {valid, ack}, {1'b0, ab});
    idle(TIMEOUT);
    send(7'b0011000);
    expect_sym(pair_idx(3, 4), ab, "R6 after discard");
    idle(1);
  endtask

  task automatic t_stall;
    logic ab;
    ready = 1'b0;
    ab = ack;
    send(7'b0000011);
    expect_sym(0, ab, "R7 first");
    ab = ack;
    send(7'b0000101);
    chk(valid && data == 0 && ack == ab, "R7 held", {valid, data, ack}, {1'b1, 4'd0, ab});
    idle(2);
    chk(valid && data == 0 && ack == ab, "R7 still held", {valid, data, ack}, {1'b1, 4'd0, ab});
    ready = 1'b1;
    @(negedge clk);
    expect_sym(1, ab, "R7 release");
    idle(1);
    chk(!valid, "R8 drained", valid, 0);
  endtask

  initial begin
    t_reset();
    t_all_codes();
    t_split();
    t_arbitrate();
    t_timeout();
    t_stall();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule